// File: doc/BRIEF.md
# Seconds Counter Peripheral with Alarm

This block keeps time in whole seconds for a system that has only a slow tick, such as a divided low-frequency oscillator that is already brought into the local clock. A reloading down-counter divides the tick into a one-second event. Each event advances a 32-bit seconds count. The count is compared with a 32-bit alarm value, and a 32-bit wrap is flagged as overflow. Software sees the block through a 16-bit register bus with ten word addresses. Each 32-bit quantity appears as a high half and a low half. Three status flags (second, alarm, overflow) each have an enable. These drive one combined interrupt line. A separate one-cycle alarm wake pulse is meant for an external rising-edge detector.

Loading a new count, prescaler reload value or alarm requires an explicit configuration window. Writes made inside the window land in shadow registers. They take effect only once the window is closed and a fixed commit delay has run out. Every accepted write holds a write-done status bit low for that delay, and the bus ignores writes while it is low. A software-clearable synchronised bit is set again by hardware whenever a commit has changed the count or the prescaler.

Top module: `rtcnt_periph`

## Requirements
- R1: After reset, word 1 (status/control) reads 0x0020, word 0 (enables) reads 0, the count reads 0, the alarm reads 0xFFFFFFFF and both the prescaler reload value and the divider read PRESC_RST. The interrupt and wake outputs are 0.
- R2: On each tick the divider (words 4 high, 5 low) decrements. A tick that finds it at 0 reloads it with the prescaler value, increments the count (words 6 high, 7 low) and sets the second flag (word 1 bit 0). One second therefore spans prescaler+1 ticks.
- R3: Writes to the prescaler (words 2/3), count or alarm (words 8/9) made while configuration mode (word 1 bit 4) is 0 are ignored and do not start a commit delay.
- R4: Any accepted write clears write-done (word 1 bit 5) for exactly COMMIT_LAT cycles, and writes issued meanwhile are dropped. Entering configuration mode copies the live values into the shadow registers. Shadow writes become visible only at the end of the delay that follows leaving configuration mode, and an unwritten half keeps its old value.
- R5: The synchronised bit (word 1 bit 3) clears when 0 is written to it. It is set at a commit that loaded the count or the prescaler, but not at a commit that loaded only the alarm.
- R6: The flags in word 1 bits 2..0 clear when 0 is written to them. Writing 1 leaves a flag unchanged.
- R7: When the count increments to the alarm value, the alarm flag (word 1 bit 1) sets. If the flag was clear, wake_o pulses high for exactly one cycle, and the pulse coincides with the flag appearing.
- R8: An increment from 0xFFFFFFFF to 0 sets the overflow flag (word 1 bit 2).
- R9: irq_o is high while any flag is set together with its enable in word 0 (bit 0 second, bit 1 alarm, bit 2 overflow), and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle tick from the slow time base |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | BUS_W | Write data |
| bus_rdata_o | output | BUS_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Combined enabled-flag interrupt |
| wake_o | output | 1 | One-cycle alarm wake pulse |

## Verification
The bench counts the write-done low window cycle by cycle. A design whose delay is off by one shows write-done early or late on the fourth or fifth read. It reads the live count between the shadow write and the end of the commit, where a write-through design would already show the new value. Writes made outside configuration mode and writes made during a pending commit are both followed by reads of the target register, which expose a design that accepts them. The alarm is placed at 0xFFFFFFFF so that alarm and wrap occur on consecutive seconds. This catches a flipped wrap comparison, a wake pulse that lasts longer than one cycle, and a synchronised bit set by an alarm-only commit.

// File: rtl/rtcnt_pkg.sv
package rtcnt_pkg;
    // Register word addresses; halves of a 32-bit value sit high then low
    localparam int A_CTLH = 0;
    localparam int A_CTLL = 1;
    localparam int A_PRSH = 2;
    localparam int A_PRSL = 3;
    localparam int A_DIVH = 4;
    localparam int A_DIVL = 5;
    localparam int A_CNTH = 6;
    localparam int A_CNTL = 7;
    localparam int A_ALMH = 8;
    localparam int A_ALML = 9;

    // Flag / enable positions (shared by both control words)
    localparam int FL_SEC = 0;
    localparam int FL_ALM = 1;
    localparam int FL_OVF = 2;
    localparam int BT_RSF = 3;
    localparam int BT_CFG = 4;
    localparam int BT_DONE = 5;

    // Pending-load mask positions
    localparam int P_PRS = 0;
    localparam int P_CNT = 1;
    localparam int P_ALM = 2;
endpackage

// File: rtl/rtcnt_divider.sv
module rtcnt_divider #(
    parameter int          W       = 32,
    parameter int unsigned RST_VAL = 32767
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] div_o,
    output logic         pulse_o
);
    logic [W-1:0] div_d, div_q;

    assign pulse_o = tick_i && !load_i && (div_q == '0);
    assign div_o   = div_q;

    always_comb begin
        div_d = div_q;
        if (load_i) begin
            div_d = load_val_i;
        end else if (tick_i) begin
            div_d = (div_q == '0) ? reload_i : div_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= W'(RST_VAL);
        else         div_q <= div_d;
    end

    // R2: a tick on a non-zero divider lowers it by one
    assert_div_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !load_i && div_q != '0) |=> div_q == $past(div_q) - 1'b1);
endmodule

// File: rtl/rtcnt_tally.sv
module rtcnt_tally #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         step_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] alarm_i,
    output logic [W-1:0] cnt_o,
    output logic         hit_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] inc;

    assign inc    = cnt_q + 1'b1;
    assign hit_o  = step_i && !load_i && (inc == alarm_i);
    assign wrap_o = step_i && !load_i && (&cnt_q);
    assign cnt_o  = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)      cnt_d = load_val_i;
        else if (step_i) cnt_d = inc;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R8: a wrap event leaves the count at zero
    assert_wrap_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> cnt_q == '0);
endmodule

// File: rtl/rtcnt_periph.sv
module rtcnt_periph
    import rtcnt_pkg::*;
#(
    parameter int          BUS_W      = 16,
    parameter int          ADDR_W     = 4,
    parameter int          COMMIT_LAT = 4,
    parameter int unsigned PRESC_RST  = 32767
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic              irq_o,
    output logic              wake_o
);
    localparam int CNT_W = 2 * BUS_W;
    localparam int LAT_W = $clog2(COMMIT_LAT + 1);

    typedef struct packed {
        logic [2:0]       en;
        logic [2:0]       flg;
        logic             rsf;
        logic             cfg;
        logic [LAT_W-1:0] busy;
        logic             commit_pend;
        logic [2:0]       pend;
        logic [CNT_W-1:0] stg_prs;
        logic [CNT_W-1:0] stg_cnt;
        logic [CNT_W-1:0] stg_alm;
        logic [CNT_W-1:0] prs;
        logic [CNT_W-1:0] alm;
        logic             wake;
    } state_t;

    state_t           st_d, st_q;
    logic             wr_ok, commit, sec_pulse, hit, wrap;
    logic [CNT_W-1:0] div_val, cnt_val;
    int               addr;

    assign addr   = int'(bus_addr_i);
    assign wr_ok  = bus_we_i && (st_q.busy == '0);
    assign commit = st_q.commit_pend && (st_q.busy == LAT_W'(1));

    rtcnt_divider #(.W(CNT_W), .RST_VAL(PRESC_RST)) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .load_i     (commit && st_q.pend[P_PRS]),
        .load_val_i (st_q.stg_prs),
        .reload_i   (st_q.prs),
        .div_o      (div_val),
        .pulse_o    (sec_pulse)
    );

    rtcnt_tally #(.W(CNT_W)) u_tally (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_i     (sec_pulse),
        .load_i     (commit && st_q.pend[P_CNT]),
        .load_val_i (st_q.stg_cnt),
        .alarm_i    (st_q.alm),
        .cnt_o      (cnt_val),
        .hit_o      (hit),
        .wrap_o     (wrap)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        if (st_q.busy != '0) st_d.busy = st_q.busy - 1'b1;

        if (commit) begin
            st_d.commit_pend = 1'b0;
            st_d.pend        = '0;
            if (st_q.pend[P_PRS]) st_d.prs = st_q.stg_prs;
            if (st_q.pend[P_ALM]) st_d.alm = st_q.stg_alm;
            if (st_q.pend[P_PRS] || st_q.pend[P_CNT]) st_d.rsf = 1'b1;
        end

        if (wr_ok) begin
            case (addr)
                A_CTLH: begin
                    st_d.en   = bus_wdata_i[2:0];
                    st_d.busy = LAT_W'(COMMIT_LAT);
                end
                A_CTLL: begin
                    st_d.flg  = st_q.flg & bus_wdata_i[2:0];
                    st_d.rsf  = st_q.rsf & bus_wdata_i[BT_RSF];
                    st_d.cfg  = bus_wdata_i[BT_CFG];
                    st_d.busy = LAT_W'(COMMIT_LAT);
                    if (!st_q.cfg && bus_wdata_i[BT_CFG]) begin
                        st_d.stg_prs = st_q.prs;
                        st_d.stg_cnt = cnt_val;
                        st_d.stg_alm = st_q.alm;
                    end
                    if (st_q.cfg && !bus_wdata_i[BT_CFG]) st_d.commit_pend = 1'b1;
                end
                A_PRSH, A_PRSL, A_CNTH, A_CNTL, A_ALMH, A_ALML: begin
                    if (st_q.cfg) begin
                        st_d.busy = LAT_W'(COMMIT_LAT);
                        case (addr)
                            A_PRSH:  begin st_d.stg_prs[BUS_W +: BUS_W] = bus_wdata_i; st_d.pend[P_PRS] = 1'b1; end
                            A_PRSL:  begin st_d.stg_prs[0 +: BUS_W]     = bus_wdata_i; st_d.pend[P_PRS] = 1'b1; end
                            A_CNTH:  begin st_d.stg_cnt[BUS_W +: BUS_W] = bus_wdata_i; st_d.pend[P_CNT] = 1'b1; end
                            A_CNTL:  begin st_d.stg_cnt[0 +: BUS_W]     = bus_wdata_i; st_d.pend[P_CNT] = 1'b1; end
                            A_ALMH:  begin st_d.stg_alm[BUS_W +: BUS_W] = bus_wdata_i; st_d.pend[P_ALM] = 1'b1; end
                            default: begin st_d.stg_alm[0 +: BUS_W]     = bus_wdata_i; st_d.pend[P_ALM] = 1'b1; end
                        endcase
                    end
                end
                default: ;
            endcase
        end

        // Hardware flag sets win over a same-cycle software clear
        if (sec_pulse) st_d.flg[FL_SEC] = 1'b1;
        if (wrap)      st_d.flg[FL_OVF] = 1'b1;
        if (hit) begin
            st_d.flg[FL_ALM] = 1'b1;
            if (!st_q.flg[FL_ALM]) st_d.wake = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q     <= '0;
            st_q.prs <= CNT_W'(PRESC_RST);
            st_q.alm <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (addr)
            A_CTLH: bus_rdata_o = BUS_W'(st_q.en);
            A_CTLL: bus_rdata_o = BUS_W'({st_q.busy == '0, st_q.cfg, st_q.rsf, st_q.flg});
            A_PRSH: bus_rdata_o = st_q.prs[BUS_W +: BUS_W];
            A_PRSL: bus_rdata_o = st_q.prs[0 +: BUS_W];
            A_DIVH: bus_rdata_o = div_val[BUS_W +: BUS_W];
            A_DIVL: bus_rdata_o = div_val[0 +: BUS_W];
            A_CNTH: bus_rdata_o = cnt_val[BUS_W +: BUS_W];
            A_CNTL: bus_rdata_o = cnt_val[0 +: BUS_W];
            A_ALMH: bus_rdata_o = st_q.alm[BUS_W +: BUS_W];
            A_ALML: bus_rdata_o = st_q.alm[0 +: BUS_W];
            default: ;
        endcase
    end

    assign irq_o  = |(st_q.flg & st_q.en);
    assign wake_o = st_q.wake;

    // R4: a write during the commit delay changes no control state
    assert_busy_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && st_q.busy != '0) |=> ($stable(st_q.en) && $stable(st_q.cfg)));

    // R3: outside configuration mode only the control words can touch the shadows
    assert_stage_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && !st_q.cfg && addr != A_CTLL)
        |=> ($stable(st_q.stg_cnt) && $stable(st_q.stg_prs) && $stable(st_q.stg_alm)));

    // R5: the synchronised bit only rises on a commit
    assert_rsf_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.rsf) |-> $past(commit));

    // R7: wake coincides with a set alarm flag and lasts one cycle
    assert_wake_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.wake |-> st_q.flg[FL_ALM]);
    assert_wake_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.wake |=> !st_q.wake);
endmodule

// File: tb/rtcnt_periph_bench.sv
module rtcnt_periph_bench;
    localparam int SRC_IRQ  = 16;
    localparam int SRC_WAKE = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'd1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq, wake;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int          src;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;

    rtcnt_periph #(.COMMIT_LAT(4), .PRESC_RST(3)) u_rtcnt_periph (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick_i      (tick),
        .bus_we_i    (we),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .wake_o      (wake)
    );

    // Monitor: pops expected items and compares them with the design
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            #1;
            begin
                item_t it;
                logic [15:0] act;
                it = sb_q[0];
                if (it.src == SRC_IRQ)       act = {15'b0, irq};
                else if (it.src == SRC_WAKE) act = {15'b0, wake};
                else                         act = rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s src=%0d actual=%h expected=%h", it.req, it.src, act, it.exp);
                end
                void'(sb_q.pop_front());
            end
        end
    end

    task automatic expect_val(int src, logic [15:0] exp, string req);
        @(negedge clk);
        if (src < 16) addr = src[3:0];
        sb_q.push_back('{src, exp, req});
        wait (sb_q.size() == 0);
    endtask

    task automatic wait_done();
        do begin
            @(negedge clk);
            addr = 4'd1;
            #1;
        end while (rdata[5] !== 1'b1);
    endtask

    task automatic bus_write(int a, logic [15:0] d);
        wait_done();
        we = 1'b1; addr = a[3:0]; wdata = d;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic bus_write_raw(int a, logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a[3:0]; wdata = d;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(posedge clk); #1;
        tick = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_val(1, 16'h0020, "R1 status");
        expect_val(0, 16'h0000, "R1 enables");
        expect_val(7, 16'h0000, "R1 count low");
        expect_val(8, 16'hFFFF, "R1 alarm high");
        expect_val(3, 16'h0003, "R1 prescaler");
        expect_val(5, 16'h0003, "R1 divider");
        expect_val(SRC_IRQ, 16'h0, "R1 irq");
        expect_val(SRC_WAKE, 16'h0, "R1 wake");

        // R2 division by prescaler+1
        for (int i = 0; i < 3; i++) do_tick();
        expect_val(5, 16'h0000, "R2 divider at zero");
        expect_val(7, 16'h0000, "R2 count before second");
        do_tick();
        expect_val(7, 16'h0001, "R2 count after second");
        expect_val(5, 16'h0003, "R2 divider reloaded");
        expect_val(1, 16'h0021, "R2 second flag");

        // R3 count write outside configuration mode
        bus_write(7, 16'h0055);
        expect_val(7, 16'h0001, "R3 count untouched");
        expect_val(1, 16'h0021, "R3 no commit delay");

        // R6 writing ones keeps flags
        bus_write(1, 16'h000F);
        wait_done();
        expect_val(1, 16'h0021, "R6 write one no effect");

        // R6 clear, R4 exact delay length
        bus_write(1, 16'h0000);
        for (int i = 0; i < 4; i++) expect_val(1, 16'h0000, "R4 write-done low");
        expect_val(1, 16'h0020, "R4 write-done back");

        // R4 configuration window
        bus_write(1, 16'h0010);
        bus_write(6, 16'hFFFF);
        bus_write(7, 16'hFFFE);
        bus_write(3, 16'h0001);
        wait_done();
        expect_val(7, 16'h0001, "R4 count before exit");
        bus_write(1, 16'h0000);
        expect_val(7, 16'h0001, "R4 count during commit");
        bus_write_raw(0, 16'h0007);
        wait_done();
        expect_val(0, 16'h0000, "R4 write during delay dropped");
        expect_val(6, 16'hFFFF, "R4 count high committed");
        expect_val(7, 16'hFFFE, "R4 count low committed");
        expect_val(2, 16'h0000, "R4 prescaler high kept");
        expect_val(3, 16'h0001, "R4 prescaler low committed");
        expect_val(5, 16'h0001, "R4 divider reloaded");
        expect_val(1, 16'h0028, "R5 sync set by count load");

        // R7 alarm at all ones, R9 irq
        bus_write(0, 16'h0007);
        expect_val(SRC_IRQ, 16'h0, "R9 irq with no flags");
        do_tick();
        do_tick();
        expect_val(SRC_WAKE, 16'h1, "R7 wake pulse");
        expect_val(SRC_WAKE, 16'h0, "R7 wake one cycle");
        expect_val(1, 16'h002B, "R7 alarm flag");
        expect_val(SRC_IRQ, 16'h1, "R9 irq with flags");

        // R8 wrap
        do_tick();
        do_tick();
        expect_val(7, 16'h0000, "R8 count wrapped");
        expect_val(1, 16'h002F, "R8 overflow flag");
        expect_val(SRC_WAKE, 16'h0, "R7 no wake on wrap");

        // R5/R6 clear all
        bus_write(1, 16'h0000);
        wait_done();
        expect_val(1, 16'h0020, "R5 sync cleared by zero");
        expect_val(SRC_IRQ, 16'h0, "R9 irq after clear");

        // R5 alarm-only commit
        bus_write(0, 16'h0001);
        bus_write(1, 16'h0010);
        bus_write(8, 16'h0000);
        bus_write(9, 16'h0003);
        bus_write(1, 16'h0000);
        wait_done();
        expect_val(8, 16'h0000, "R4 alarm high committed");
        expect_val(9, 16'h0003, "R4 alarm low committed");
        expect_val(1, 16'h0020, "R5 no sync on alarm only");

        // R9 per-enable mapping
        do_tick();
        do_tick();
        expect_val(1, 16'h0021, "R2 second flag again");
        expect_val(SRC_IRQ, 16'h1, "R9 second enable");
        bus_write(0, 16'h0002);
        wait_done();
        expect_val(SRC_IRQ, 16'h0, "R9 second not enabled");
        for (int i = 0; i < 4; i++) do_tick();
        expect_val(SRC_WAKE, 16'h1, "R7 wake at alarm 3");
        expect_val(7, 16'h0003, "R7 count at alarm");
        expect_val(1, 16'h0023, "R7 alarm flag again");
        expect_val(SRC_IRQ, 16'h1, "R9 alarm enable");
        expect_val(0, 16'h0002, "R9 enable readback");

        // R3 alarm and prescaler outside configuration mode
        bus_write(9, 16'h0009);
        bus_write(3, 16'h0007);
        expect_val(9, 16'h0003, "R3 alarm untouched");
        expect_val(3, 16'h0001, "R3 prescaler untouched");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule